// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block is the request and service core of two chained 8-line interrupt controllers that together serve 16 request lines. Lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary one. Each controller holds a request register, a mask register, an in-service register, a trigger-mode register and a rotating lowest-priority pointer. Line 2 of the primary controller is the chaining input: any secondary request also raises primary request bit 2.

Request lines arrive as one-cycle assert and deassert pulses. An acknowledge pulse moves the winning request into service and returns a 16-bit vector, which is the controller's base plus the line index. The block searches the primary controller first. If no primary line qualifies, it searches the secondary controller. A separate command port ends service and moves the priority pointer. The mask and trigger-mode registers are written through byte-wide write enables. All registers can be read on output ports.

Top module: `cascade_irq_core`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - All request, in-service, mask and trigger-mode registers read zero.
  - `ack_vec` reads 16'hFFFF and `ack_vld` is low.
  - Both lowest-priority pointers are 7, so line 0 is searched first.
- R2: `pending` is high exactly when one of these is nonzero:
  - the primary request register AND NOT (primary mask OR bit 2);
  - the secondary request register AND NOT the secondary mask.
- R3: An assert pulse on a line in the range 8 to 15 sets the matching secondary request bit and also sets primary request bit 2.
- R4: A deassert pulse clears a request bit only if that line's trigger-mode bit is 1 (level). Edge lines (bit 0) keep their request. When a level deassert leaves the secondary request register at zero, primary request bit 2 is also cleared.
- R5: Within each controller, the search starts at (pointer + 1) mod 8 and wraps circularly. The first unmasked set request found wins.
- R6: The primary controller is searched first, and its line 2 is never granted. The secondary controller is searched only if no primary line qualifies.
- R7: On acknowledge, the winning request bit is cleared and its in-service bit is set. `ack_vec` becomes base + index, and `ack_vld` pulses, both in the cycle after the acknowledge edge.
- R8: Granting a secondary line also clears primary request bit 2 and sets primary in-service bit 2.
- R9: An acknowledge with no qualifying line returns 16'hFFFF and changes no request or in-service bit.
- R10: The end-of-interrupt commands act on the selected controller:
  - `cmd_op` 1 (specific) clears in-service bit `cmd_line`;
  - `cmd_op` 0 (nonspecific) clears the lowest-numbered set in-service bit.
  - `cmd_sel` 0 selects the primary controller and 1 the secondary.
- R11: `cmd_op` 3 and 2 behave like 1 and 0, and also increment the pointer mod 8. `cmd_op` 4 loads the pointer with `cmd_line`. Codes 5 to 7 do nothing.
- R12: Mask and trigger-mode registers are written through the enables. Enable bit 0 targets the primary controller and bit 1 the secondary. The registers read back on `imr_*` and `trig_*`.
- R13: Assert and deassert pulses in a cycle take effect before an acknowledge in the same cycle, so that acknowledge can grant a line asserted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rise | input | 16 | One-cycle assert pulses, one bit per line |
| req_fall | input | 16 | One-cycle deassert pulses, one bit per line |
| ack | input | 1 | Acknowledge pulse |
| base_m | input | 8 | Primary vector base |
| base_s | input | 8 | Secondary vector base |
| ack_vec | output | 16 | Vector returned by the last acknowledge |
| ack_vld | output | 1 | High in the cycle after an acknowledge edge |
| cmd_vld | input | 1 | Command strobe |
| cmd_sel | input | 1 | 0 primary, 1 secondary |
| cmd_op | input | 3 | Command code (see R10, R11) |
| cmd_line | input | 3 | Line argument of the command |
| mask_we | input | 2 | Mask write enables (bit 0 primary, bit 1 secondary) |
| mask_wdata | input | 8 | Mask write data |
| trig_we | input | 2 | Trigger-mode write enables |
| trig_wdata | input | 8 | Trigger-mode write data, 1 = level |
| irr_m | output | 8 | Primary request register |
| irr_s | output | 8 | Secondary request register |
| isr_m | output | 8 | Primary in-service register |
| isr_s | output | 8 | Secondary in-service register |
| imr_m | output | 8 | Primary mask register |
| imr_s | output | 8 | Secondary mask register |
| trig_m | output | 8 | Primary trigger-mode register |
| trig_s | output | 8 | Secondary trigger-mode register |
| pending | output | 1 | A qualifying request exists |

## Verification
A corrupted request, in-service or mask bit appears on its read-back port and on `pending` one cycle after the edge that wrote it. A wrong priority pointer stays invisible until an acknowledge meets two competing requests. For that reason the bench loads the pointer to specific values and checks that a rotate makes the formerly lowest line win. Errors in chaining, where bit 2 is left set or cleared wrongly, show up later: either as a stale `pending` or as a missing secondary grant on a following acknowledge.

// File: rtl/cascade_irq_pkg.sv
// Shared command codes for the cascaded interrupt resolver.
package cascade_irq_pkg;
    typedef enum logic [2:0] {
        CMD_EOI_ANY  = 3'd0,
        CMD_EOI_LINE = 3'd1,
        CMD_ROT_ANY  = 3'd2,
        CMD_ROT_LINE = 3'd3,
        CMD_SET_LOW  = 3'd4
    } cmd_op_e;
endpackage

// File: rtl/prio_scan.sv
// Rotating priority search: returns the first set request starting at
// (lowest + 1) and wrapping. Assumes N is a power of two so that index
// arithmetic wraps naturally.
module prio_scan #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] lowest,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] pos;

    // Walk from the lowest-priority slot backwards so the earliest hit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = lowest + IW'(1) + IW'(k);
            if (req[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end
endmodule

// File: rtl/irq_bank.sv
// Register set of one 8-line controller: requests, mask, in-service,
// trigger mode and rotating pointer. Applies set, then clear, then the
// acknowledge take. Commands act on the in-service value from before a
// same-cycle take. Assumes N is a power of two.
module irq_bank
    import cascade_irq_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_vec,
    input  logic [N-1:0]  lvl_clr_vec,
    input  logic [N-1:0]  force_clr_vec,
    input  logic [N-1:0]  take_vec,
    input  logic          cmd_vld,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_line,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          trig_we,
    input  logic [N-1:0]  trig_wdata,
    output logic [N-1:0]  irr_mid,
    output logic [N-1:0]  irr_q,
    output logic [N-1:0]  isr_q,
    output logic [N-1:0]  imr_q,
    output logic [N-1:0]  trig_q,
    output logic [IW-1:0] lowest_q
);
    logic [N-1:0]  eoi_clr;
    logic [IW-1:0] lowest_nxt;
    cmd_op_e       op;

    assign op = cmd_op_e'(cmd_op);

    // Requests after this cycle's assert and level-qualified deassert.
    assign irr_mid = (irr_q | set_vec) & ~((lvl_clr_vec & trig_q) | force_clr_vec);

    // Decode the end-of-service and pointer commands.
    always_comb begin
        eoi_clr    = '0;
        lowest_nxt = lowest_q;
        if (cmd_vld) begin
            case (op)
                CMD_EOI_ANY:  eoi_clr = isr_q & (~isr_q + N'(1));
                CMD_EOI_LINE: eoi_clr = N'(1) << cmd_line;
                CMD_ROT_ANY: begin
                    eoi_clr    = isr_q & (~isr_q + N'(1));
                    lowest_nxt = lowest_q + IW'(1);
                end
                CMD_ROT_LINE: begin
                    eoi_clr    = N'(1) << cmd_line;
                    lowest_nxt = lowest_q + IW'(1);
                end
                CMD_SET_LOW:  lowest_nxt = cmd_line;
                default: ;
            endcase
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q    <= '0;
            isr_q    <= '0;
            imr_q    <= '0;
            trig_q   <= '0;
            lowest_q <= IW'(N - 1);
        end else begin
            irr_q    <= irr_mid & ~take_vec;
            isr_q    <= (isr_q & ~eoi_clr) | take_vec;
            lowest_q <= lowest_nxt;
            if (mask_we) imr_q  <= mask_wdata;
            if (trig_we) trig_q <= trig_wdata;
        end
    end

    assert_take_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vec != '0) |=> (((isr_q & $past(take_vec)) == $past(take_vec))
                              && ((irr_q & $past(take_vec)) == '0)));

    assert_rotate_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3))
        |=> (lowest_q == IW'($past(lowest_q) + IW'(1))));

    assert_edge_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (1'b1) |=> ((irr_q & $past(irr_q & ~trig_q & ~take_vec & ~force_clr_vec))
                    == $past(irr_q & ~trig_q & ~take_vec & ~force_clr_vec)));
endmodule

// File: rtl/cascade_irq_core.sv
// Top of the cascaded resolver: two irq_bank instances, chaining through
// primary line CASC, primary-first acknowledge arbitration and the
// registered vector output.
module cascade_irq_core #(
    parameter int N      = 8,
    parameter int CASC   = 2,
    parameter int BASE_W = 8,
    parameter int VEC_W  = 16,
    localparam int IW    = $clog2(N),
    localparam int L     = 2 * N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [L-1:0]      req_rise,
    input  logic [L-1:0]      req_fall,
    input  logic              ack,
    input  logic [BASE_W-1:0] base_m,
    input  logic [BASE_W-1:0] base_s,
    output logic [VEC_W-1:0]  ack_vec,
    output logic              ack_vld,
    input  logic              cmd_vld,
    input  logic              cmd_sel,
    input  logic [2:0]        cmd_op,
    input  logic [IW-1:0]     cmd_line,
    input  logic [1:0]        mask_we,
    input  logic [N-1:0]      mask_wdata,
    input  logic [1:0]        trig_we,
    input  logic [N-1:0]      trig_wdata,
    output logic [N-1:0]      irr_m,
    output logic [N-1:0]      irr_s,
    output logic [N-1:0]      isr_m,
    output logic [N-1:0]      isr_s,
    output logic [N-1:0]      imr_m,
    output logic [N-1:0]      imr_s,
    output logic [N-1:0]      trig_m,
    output logic [N-1:0]      trig_s,
    output logic              pending
);
    localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

    logic [N-1:0]     m_mid, s_mid, m_set, m_force, m_take, s_take, m_q, s_q;
    logic [IW-1:0]    m_low, s_low, m_idx, s_idx;
    logic             m_found, s_found;
    logic [VEC_W-1:0] vec_nxt;

    // Primary sees its own lines plus the chained secondary request.
    assign m_set = req_rise[N-1:0] | ((|req_rise[L-1:N]) ? CASC_BIT : '0);

    // Drop chain bit when a level deassert empties the secondary requests.
    assign m_force = ((|(req_fall[L-1:N] & trig_s)) && (s_mid == '0)) ? CASC_BIT : '0;

    // Qualifying requests for this cycle's acknowledge.
    assign m_q = m_mid & ~imr_m & ~CASC_BIT;
    assign s_q = s_mid & ~imr_s;

    prio_scan #(.N(N)) u_scan_m (.req(m_q), .lowest(m_low), .found(m_found), .idx(m_idx));
    prio_scan #(.N(N)) u_scan_s (.req(s_q), .lowest(s_low), .found(s_found), .idx(s_idx));

    // Arbitration: primary first, secondary only when primary is empty.
    always_comb begin
        m_take  = '0;
        s_take  = '0;
        vec_nxt = '1;
        if (ack) begin
            if (m_found) begin
                m_take  = N'(1) << m_idx;
                vec_nxt = VEC_W'(base_m) + VEC_W'(m_idx);
            end else if (s_found) begin
                s_take  = N'(1) << s_idx;
                m_take  = CASC_BIT;
                vec_nxt = VEC_W'(base_s) + VEC_W'(s_idx);
            end
        end
    end

    irq_bank #(.N(N)) u_bank_m (
        .clk(clk), .rst_n(rst_n),
        .set_vec(m_set), .lvl_clr_vec(req_fall[N-1:0]), .force_clr_vec(m_force),
        .take_vec(m_take),
        .cmd_vld(cmd_vld && !cmd_sel), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .mask_we(mask_we[0]), .mask_wdata(mask_wdata),
        .trig_we(trig_we[0]), .trig_wdata(trig_wdata),
        .irr_mid(m_mid), .irr_q(irr_m), .isr_q(isr_m), .imr_q(imr_m),
        .trig_q(trig_m), .lowest_q(m_low)
    );

    irq_bank #(.N(N)) u_bank_s (
        .clk(clk), .rst_n(rst_n),
        .set_vec(req_rise[L-1:N]), .lvl_clr_vec(req_fall[L-1:N]), .force_clr_vec('0),
        .take_vec(s_take),
        .cmd_vld(cmd_vld && cmd_sel), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .mask_we(mask_we[1]), .mask_wdata(mask_wdata),
        .trig_we(trig_we[1]), .trig_wdata(trig_wdata),
        .irr_mid(s_mid), .irr_q(irr_s), .isr_q(isr_s), .imr_q(imr_s),
        .trig_q(trig_s), .lowest_q(s_low)
    );

    // Pending from registered state, chain bit excluded on the primary.
    assign pending = (|(irr_m & ~(imr_m | CASC_BIT))) || (|(irr_s & ~imr_s));

    // Register the returned vector and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vec <= '1;
            ack_vld <= 1'b0;
        end else begin
            ack_vld <= ack;
            if (ack) ack_vec <= vec_nxt;
        end
    end

    assert_chain_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_rise[L-1:N]) && !ack && !(|req_fall[L-1:N])) |=> irr_m[CASC]);

    assert_chain_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_take[CASC] |-> (s_take != '0));

    assert_empty_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !m_found && !s_found) |=> (ack_vec == '1));

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_take) && $onehot0(m_take & ~CASC_BIT));
endmodule

// File: tb/cascade_irq_core_bench.sv
module cascade_irq_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_rise, req_fall;
    logic        ack;
    logic [7:0]  base_m, base_s;
    logic [15:0] ack_vec;
    logic        ack_vld;
    logic        cmd_vld, cmd_sel;
    logic [2:0]  cmd_op, cmd_line;
    logic [1:0]  mask_we, trig_we;
    logic [7:0]  mask_wdata, trig_wdata;
    logic [7:0]  irr_m, irr_s, isr_m, isr_s, imr_m, imr_s, trig_m, trig_s;
    logic        pending;
    int n_chk = 0;
    int n_err = 0;

    cascade_irq_core u_cascade_irq_core (.*);

    always #5 clk = ~clk;

    // {rise[15:0], ack, expected vec[15:0], expected pending}
    localparam logic [33:0] TBL [0:9] = '{
        {16'h0020, 1'b0, 16'hFFFF, 1'b1},  // primary line 5 pends
        {16'h0400, 1'b0, 16'hFFFF, 1'b1},  // secondary line 10, chain bit (R3)
        {16'h0000, 1'b1, 16'h0025, 1'b1},  // primary wins first (R6)
        {16'h0000, 1'b1, 16'h002A, 1'b0},  // secondary grant (R8)
        {16'h0000, 1'b1, 16'hFFFF, 1'b0},  // nothing left (R9)
        {16'h0081, 1'b1, 16'h0020, 1'b1},  // same-cycle assert, line 0 first (R13, R5)
        {16'h0000, 1'b1, 16'h0027, 1'b0},
        {16'h8100, 1'b1, 16'h0028, 1'b1},  // secondary lines 8 and 15
        {16'h0000, 1'b1, 16'h002F, 1'b0},
        {16'h0004, 1'b1, 16'hFFFF, 1'b0}   // primary line 2 never granted (R6)
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_rise = '0; req_fall = '0; ack = 1'b0; cmd_vld = 1'b0;
        mask_we = '0; trig_we = '0;
    endtask

    task automatic cyc(input logic [15:0] r, input logic [15:0] f, input logic a);
        req_rise = r; req_fall = f; ack = a;
        @(negedge clk);
        quiet();
    endtask

    task automatic cmd(input logic sel, input logic [2:0] op, input logic [2:0] ln);
        cmd_vld = 1'b1; cmd_sel = sel; cmd_op = op; cmd_line = ln;
        @(negedge clk);
        quiet();
    endtask

    task automatic wr_mask(input logic [1:0] we, input logic [7:0] d);
        mask_we = we; mask_wdata = d;
        @(negedge clk);
        quiet();
    endtask

    task automatic wr_trig(input logic [1:0] we, input logic [7:0] d);
        trig_we = we; trig_wdata = d;
        @(negedge clk);
        quiet();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        quiet();
        cmd_sel = 1'b0; cmd_op = '0; cmd_line = '0; mask_wdata = '0; trig_wdata = '0;
        base_m = 8'h20; base_s = 8'h28;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(irr_m == 0 && irr_s == 0 && isr_m == 0 && isr_s == 0, "R1 req/service", {irr_m, isr_m}, 16'h0);
        chk(imr_m == 0 && imr_s == 0 && trig_m == 0 && trig_s == 0, "R1 mask/trig", {imr_m, trig_m}, 16'h0);
        chk(ack_vec == 16'hFFFF && !ack_vld && !pending, "R1 vector", ack_vec, 16'hFFFF);

        for (int i = 0; i < 10; i++) begin
            cyc(TBL[i][33:18], 16'h0, TBL[i][17]);
            chk(ack_vec == TBL[i][16:1], "R5 R6 R7 R9 table vector", ack_vec, TBL[i][16:1]);
            chk(pending == TBL[i][0], "R2 table pending", {15'h0, pending}, {15'h0, TBL[i][0]});
        end
        chk(isr_m == 8'hA5, "R8 primary service", {8'h0, isr_m}, 16'h00A5);
        chk(isr_s == 8'h85, "R7 secondary service", {8'h0, isr_s}, 16'h0085);

        // R10 end-of-service commands
        cmd(1'b0, 3'd0, 3'd0);
        chk(isr_m == 8'hA4, "R10 nonspecific primary", {8'h0, isr_m}, 16'h00A4);
        cmd(1'b0, 3'd1, 3'd7);
        chk(isr_m == 8'h24, "R10 specific primary", {8'h0, isr_m}, 16'h0024);
        cmd(1'b1, 3'd1, 3'd2);
        chk(isr_s == 8'h81, "R10 specific secondary", {8'h0, isr_s}, 16'h0081);
        cmd(1'b1, 3'd0, 3'd0);
        chk(isr_s == 8'h80, "R10 nonspecific secondary", {8'h0, isr_s}, 16'h0080);
        cmd(1'b1, 3'd6, 3'd0);
        chk(isr_s == 8'h80, "R11 unused code", {8'h0, isr_s}, 16'h0080);

        // R5 and R11 pointer control
        do_reset();
        cyc(16'h000A, 16'h0, 1'b0);
        cmd(1'b0, 3'd4, 3'd3);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'h0021 && isr_m == 8'h02, "R5 loaded pointer", ack_vec, 16'h0021);
        cmd(1'b0, 3'd3, 3'd1);
        chk(isr_m == 8'h00, "R10 rotate specific clear", {8'h0, isr_m}, 16'h0);
        cyc(16'h0010, 16'h0, 1'b0);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'h0023, "R11 rotated order", ack_vec, 16'h0023);
        cmd(1'b0, 3'd2, 3'd0);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'h0024 && isr_m == 8'h10, "R11 rotate nonspecific", ack_vec, 16'h0024);

        // R12 and R2 masking
        wr_mask(2'b01, 8'h10);
        cyc(16'h0010, 16'h0, 1'b0);
        chk(imr_m == 8'h10 && !pending, "R2 masked primary", {imr_m, 7'h0, pending}, 16'h1000);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'hFFFF && irr_m == 8'h10, "R9 masked ack", ack_vec, 16'hFFFF);
        wr_mask(2'b01, 8'h00);
        chk(pending, "R2 unmasked", {15'h0, pending}, 16'h1);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'h0024, "R7 after unmask", ack_vec, 16'h0024);
        wr_mask(2'b10, 8'hFF);
        cyc(16'h0100, 16'h0, 1'b0);
        chk(imr_s == 8'hFF && !pending, "R12 R2 masked secondary", {imr_s, 7'h0, pending}, 16'hFF00);
        wr_mask(2'b10, 8'h00);
        cyc(16'h0, 16'h0, 1'b1);
        chk(ack_vec == 16'h0028 && !pending, "R8 secondary after unmask", ack_vec, 16'h0028);

        // R4 trigger modes
        wr_trig(2'b01, 8'h01);
        wr_trig(2'b10, 8'h02);
        chk(trig_m == 8'h01 && trig_s == 8'h02, "R12 trigger readback", {trig_m, trig_s}, 16'h0102);
        cyc(16'h0041, 16'h0, 1'b0);
        cyc(16'h0, 16'h0041, 1'b0);
        chk((irr_m & 8'h41) == 8'h40, "R4 level vs edge primary", {8'h0, irr_m & 8'h41}, 16'h0040);
        cyc(16'h0200, 16'h0, 1'b0);
        chk(irr_s == 8'h02 && irr_m[2], "R3 chain set", {irr_s, irr_m}, {8'h02, irr_m | 8'h04});
        cyc(16'h0, 16'h0200, 1'b0);
        chk(irr_s == 8'h00 && !irr_m[2], "R4 level drop chain", {irr_s, irr_m}, {8'h00, irr_m & 8'hFB});
        cyc(16'h0400, 16'h0, 1'b0);
        cyc(16'h0, 16'h0400, 1'b0);
        chk(irr_s == 8'h04 && irr_m[2], "R4 edge secondary kept", {irr_s, irr_m}, {8'h04, irr_m | 8'h04});

        // R13 assert and acknowledge together
        do_reset();
        cyc(16'h0008, 16'h0, 1'b1);
        chk(ack_vec == 16'h0023 && irr_m == 8'h00 && isr_m == 8'h08, "R13 same-cycle grant", ack_vec, 16'h0023);
        chk(ack_vld == 1'b1, "R7 strobe", {15'h0, ack_vld}, 16'h1);

        summary();
        $finish;
    end
endmodule